// File: doc/BRIEF.md
# SIMD Floating-Point Control and Status Register

This block is the 32-bit control and status word for a SIMD floating-point unit. It holds the rounding direction, a flush-to-zero control, a denormals-are-zero control, one mask bit per exception class and one sticky flag per exception class. Software writes the whole word through a write-enabled port and reads it back at any time through a combinational read port. The execution unit reports exceptions through a 6-bit event vector, one bit per class, in each cycle.

The block drives decoded controls straight to the datapath: a 2-bit rounding code, the flush-to-zero and denormals-are-zero enables, and a trap request. The trap request is raised in the same cycle when a reported event hits a class whose mask bit is clear. The flags are sticky. Once set, a flag changes only when software writes it, and a software write can never clear a flag whose event arrives in the same cycle.

Top module: `simd_fp_csr`

## Requirements
- R1: After reset is released, the read port shows 0x00001F80. All six mask bits (bits 12:7) are set and every other bit is clear.
- R2: When wr_en_i is high and no event is reported, the read port shows wr_data_i[15:0] from the next cycle onward.
- R3: Event bit i sets flag bit i in the next cycle. The classes are bit 0 invalid, bit 1 denormal, bit 2 divide-by-zero, bit 3 overflow, bit 4 underflow and bit 5 precision. A repeated event leaves the flag at 1.
- R4: A set flag stays set through idle cycles. A software write with 0 in that bit is the only thing that clears it.
- R5: When a write and an event occur in the same cycle, each flag becomes the written bit ORed with its event bit.
- R6: Bits 31:16 always read as zero, and write data in those bits is ignored.
- R7: trap_req_o is high in the same cycle exactly when some event bit i is set while mask bit 7+i of the current register value is clear.
- R8: round_mode_o equals {bit 14, bit 13}. The codes are 00 round to nearest, 01 toward negative (bit 13), 10 toward positive (bit 14) and 11 toward zero (both bits set).
- R9: flush_zero_o follows bit 15, and denorm_zero_o follows bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Software write data |
| exc_evt_i | input | 6 | Exception events reported this cycle, one bit per class |
| rd_data_o | output | 32 | Current register value |
| round_mode_o | output | 2 | Rounding code for the datapath |
| flush_zero_o | output | 1 | Flush-to-zero enable |
| denorm_zero_o | output | 1 | Denormals-are-zero enable |
| trap_req_o | output | 1 | Unmasked exception in this cycle |

## Verification
The stimulus covers single-class events under full masking, to separate flag setting from trap raising. It repeats an event and then runs idle cycles to tell sticky behaviour from toggling. Writes that clear flags while a different event fires, and writes that set one flag while another class fires, tell the write-then-OR order apart from write-wins or event-wins. Each class is also fired against all-clear masks and against a pattern where only one mask is clear, which shows whether the trap uses the matching mask bit. All four rounding codes and both zeroing controls are written and read back, and the write data includes junk in the upper half.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int unsigned CSR_W    = 32;
  localparam int unsigned NUM_EXC  = 6;
  localparam int unsigned DAZ_BIT  = NUM_EXC;
  localparam int unsigned MASK_LSB = DAZ_BIT + 1;
  localparam int unsigned RND_LSB  = MASK_LSB + NUM_EXC;
  localparam int unsigned FZ_BIT   = RND_LSB + 2;
  localparam int unsigned USED_W   = FZ_BIT + 1;
  localparam int unsigned CTRL_W   = USED_W - NUM_EXC;
  localparam int unsigned RSVD_W   = CSR_W - USED_W;

  // ctrl word layout: [0] daz, [NUM_EXC:1] masks, [+2] rounding, [top] fz
  localparam int unsigned C_DAZ  = 0;
  localparam int unsigned C_MASK = 1;
  localparam int unsigned C_RND  = C_MASK + NUM_EXC;
  localparam int unsigned C_FZ   = C_RND + 2;

  localparam logic [CTRL_W-1:0] CTRL_RST =
    {{(CTRL_W-NUM_EXC-1){1'b0}}, {NUM_EXC{1'b1}}, 1'b0};

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/fpcsr_flag_cell.sv
module fpcsr_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  input  logic evt_i,
  output logic flag_o
);
  // write applied first, event ORed on top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_o <= 1'b0;
    else if (wr_en_i || evt_i)  flag_o <= (wr_en_i & wr_bit_i) | evt_i;
  end
endmodule

// File: rtl/fpcsr_ctrl_reg.sv
module fpcsr_ctrl_reg
  import fpcsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_ctrl_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_o <= CTRL_RST;
    else if (wr_en_i) ctrl_o <= wr_ctrl_i;
  end
endmodule

// File: rtl/fpcsr_decode.sv
module fpcsr_decode
  import fpcsr_pkg::*;
(
  input  logic [CTRL_W-1:0]  ctrl_i,
  input  logic [NUM_EXC-1:0] evt_i,
  output logic [1:0]         round_mode_o,
  output logic               flush_zero_o,
  output logic               denorm_zero_o,
  output logic               trap_req_o
);
  rnd_mode_e rnd;
  logic [NUM_EXC-1:0] unmasked;

  always_comb begin
    rnd           = rnd_mode_e'(ctrl_i[C_RND +: 2]);
    round_mode_o  = rnd;
    flush_zero_o  = ctrl_i[C_FZ];
    denorm_zero_o = ctrl_i[C_DAZ];
    unmasked      = evt_i & ~ctrl_i[C_MASK +: NUM_EXC];
    trap_req_o    = |unmasked;
  end
endmodule

// File: rtl/simd_fp_csr.sv
module simd_fp_csr
  import fpcsr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [CSR_W-1:0]   wr_data_i,
  input  logic [NUM_EXC-1:0] exc_evt_i,
  output logic [CSR_W-1:0]   rd_data_o,
  output logic [1:0]         round_mode_o,
  output logic               flush_zero_o,
  output logic               denorm_zero_o,
  output logic               trap_req_o
);
  logic [NUM_EXC-1:0] flags_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic               unused_hi;

  assign unused_hi = ^wr_data_i[CSR_W-1:USED_W];

  for (genvar i = 0; i < NUM_EXC; i++) begin : g_flag
    fpcsr_flag_cell u_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i),
      .wr_bit_i (wr_data_i[i]),
      .evt_i    (exc_evt_i[i]),
      .flag_o   (flags_q[i])
    );
  end

  fpcsr_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_ctrl_i (wr_data_i[USED_W-1:NUM_EXC]),
    .ctrl_o    (ctrl_q)
  );

  fpcsr_decode u_dec (
    .ctrl_i        (ctrl_q),
    .evt_i         (exc_evt_i),
    .round_mode_o  (round_mode_o),
    .flush_zero_o  (flush_zero_o),
    .denorm_zero_o (denorm_zero_o),
    .trap_req_o    (trap_req_o)
  );

  assign rd_data_o = {{RSVD_W{1'b0}}, ctrl_q, flags_q};
endmodule

// File: rtl/fpcsr_checker.sv
module fpcsr_checker
  import fpcsr_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [CSR_W-1:0]   wr_data_i,
  input logic [NUM_EXC-1:0] exc_evt_i,
  input logic [CSR_W-1:0]   rd_data_o,
  input logic [1:0]         round_mode_o,
  input logic               flush_zero_o,
  input logic               denorm_zero_o,
  input logic               trap_req_o
);
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && exc_evt_i == '0) |=> rd_data_o[USED_W-1:0] == $past(wr_data_i[USED_W-1:0]));

  a_r3_event_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_evt_i != '0) |=> (rd_data_o[NUM_EXC-1:0] & $past(exc_evt_i)) == $past(exc_evt_i));

  a_r4_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (rd_data_o[NUM_EXC-1:0] & $past(rd_data_o[NUM_EXC-1:0]))
                 == $past(rd_data_o[NUM_EXC-1:0]));

  a_r5_write_or_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[NUM_EXC-1:0] == ($past(wr_data_i[NUM_EXC-1:0]) | $past(exc_evt_i)));

  a_r6_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[CSR_W-1:USED_W] == '0);

  a_r7_trap_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> exc_evt_i != '0);

  a_r7_unmasked_traps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((exc_evt_i & ~rd_data_o[MASK_LSB +: NUM_EXC]) != '0) |-> trap_req_o);

  a_r8_round_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    round_mode_o == rd_data_o[RND_LSB +: 2]);

  a_r9_zero_ctrls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_zero_o == rd_data_o[FZ_BIT] && denorm_zero_o == rd_data_o[DAZ_BIT]);
endmodule

bind simd_fp_csr fpcsr_checker u_chk (.*);

// File: tb/tb_simd_fp_csr.sv
`timescale 1ns/1ps
module tb_simd_fp_csr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [5:0]  exc_evt_i = '0;
  logic [31:0] rd_data_o;
  logic [1:0]  round_mode_o;
  logic        flush_zero_o, denorm_zero_o, trap_req_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] m_reg;
  string       tag_q[$];
  logic [31:0] rd_q[$];
  logic        trap_q[$];

  always #2.5 clk_i = ~clk_i;

  simd_fp_csr dut (.*);

  // driver: one cycle of stimulus, pushes outputs expected during this cycle
  task automatic cyc(input logic we, input logic [31:0] wd, input logic [5:0] ev, input string req);
    @(posedge clk_i); #1;
    wr_en_i = we; wr_data_i = wd; exc_evt_i = ev;
    tag_q.push_back(req);
    rd_q.push_back(m_reg);
    trap_q.push_back(|(ev & ~m_reg[12:7]));
    if (we) m_reg = {16'h0, wd[15:0]};
    m_reg[5:0] = m_reg[5:0] | ev;
  endtask

  // monitor: compares at mid-cycle
  initial begin
    forever begin
      @(negedge clk_i);
      if (tag_q.size() > 0) begin
        string r; logic [31:0] er; logic et; bit bad;
        r = tag_q.pop_front(); er = rd_q.pop_front(); et = trap_q.pop_front();
        bad = 0; n_vec++;
        if (rd_data_o !== er) begin bad = 1;
          $display("FAIL %s rd_data_o got %h exp %h", r, rd_data_o, er); end
        if (trap_req_o !== et) begin bad = 1;
          $display("FAIL %s trap_req_o got %b exp %b", r, trap_req_o, et); end
        if (round_mode_o !== er[14:13]) begin bad = 1;
          $display("FAIL %s/R8 round_mode_o got %b exp %b", r, round_mode_o, er[14:13]); end
        if (flush_zero_o !== er[15] || denorm_zero_o !== er[6]) begin bad = 1;
          $display("FAIL %s/R9 fz,daz got %b%b exp %b%b", r, flush_zero_o, denorm_zero_o, er[15], er[6]); end
        if (bad) n_bad++;
      end
    end
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired got hang exp finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    m_reg = 32'h0000_1F80;
    #11 rst_ni = 1'b1;
    cyc(0, 0, 0, "R1");                       // reset value
    cyc(1, 32'hABCD_1F80 | 32'h4040, 0, "R2"); // junk upper half, fz clear, daz set
    cyc(0, 0, 0, "R6");
    cyc(1, 32'h0000_9F80, 0, "R9");            // fz set
    cyc(1, 32'hFFFF_1F80 | 32'h2000, 0, "R8"); // toward negative
    cyc(1, 32'h0000_5F80, 0, "R8");            // toward positive
    cyc(1, 32'h0000_7F80, 0, "R8");            // toward zero
    cyc(1, 32'h0000_1F80, 0, "R8");            // nearest
    for (int i = 0; i < 6; i++) cyc(0, 0, 6'(1 << i), "R3");
    cyc(0, 0, 6'h01, "R3");                    // repeat
    cyc(0, 0, 0, "R4");
    cyc(0, 0, 0, "R4");
    cyc(1, 32'h0000_1F80, 6'h04, "R5");        // clear all, divide-by-zero fires
    cyc(0, 0, 0, "R5");
    cyc(1, 32'h0000_1F81, 6'h02, "R5");        // write invalid, denormal fires
    cyc(1, 32'h0000_1F80, 0, "R4");            // explicit clear
    cyc(0, 0, 0, "R4");
    cyc(1, 32'h0000_0000, 0, "R2");            // unmask all
    for (int i = 0; i < 6; i++) cyc(0, 0, 6'(1 << i), "R7");
    cyc(1, 32'h0000_1F00, 0, "R7");            // only invalid unmasked
    cyc(0, 0, 6'h02, "R7");
    cyc(0, 0, 6'h3E, "R7");
    cyc(0, 0, 6'h01, "R7");
    cyc(0, 0, 0, "R7");
    @(posedge clk_i); #1; wr_en_i = 0; exc_evt_i = 0;
    repeat (3) @(posedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule